// File: doc/BRIEF.md
# Per-Queue Tail Aggregation Buffer

This block sits in front of a slow, wide bulk memory that holds many logical FIFOs. Narrow data units arrive at most one per cycle, each tagged with the number of the queue it belongs to. For every queue the block keeps a partial wide block. It places each unit into the next free lane of its queue's partial block. When a queue's block fills up, the complete block goes into a small pending-write FIFO. A pacer takes blocks from that FIFO and issues them as wide write requests, no more often than the bulk memory can accept them.

A wide block always holds data from exactly one queue, and its lanes follow arrival order. When the pending-write FIFO is full, the block deasserts its input-ready signal. No unit is ever dropped. The unit width, lane count, queue count, FIFO depth and write period are all parameters. By default a unit is 40 bytes and a block is eight lanes, or 320 bytes.

Top module: `tail_agg_buffer`

## Requirements
- R1: After synchronous active-low reset, `wr_valid` is low, `in_ready` is high and every queue's partial block is empty.
- R2: Lane k of `wr_data` (bits `k*UNIT_W` up to `k*UNIT_W+UNIT_W-1`) holds the k-th unit accepted for that queue since its previous block was completed, with k counted from 0.
- R3: Every emitted block contains units of a single queue only, and `wr_qid` carries the number of that queue.
- R4: A block is emitted only after its LANES-th unit has been accepted. Blocks are emitted in the order in which they were completed, across all queues.
- R5: Two consecutive write requests are at least WR_PERIOD cycles apart, and WR_PERIOD is at least LANES.
- R6: `in_ready` is low exactly when the pending-write FIFO is full. Every accepted unit appears exactly once in the output.
- R7: `wr_valid` is a single-cycle pulse for each block.
- R8: A unit that is presented while `in_ready` is low is not taken. It has no effect on any queue's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An input unit is presented |
| in_ready | output | 1 | The unit is taken at this edge when `in_valid` is high |
| in_qid | input | $clog2(NQ) | Queue number of the unit |
| in_data | input | UNIT_W | Unit payload |
| wr_valid | output | 1 | Wide write request, one-cycle pulse |
| wr_qid | output | $clog2(NQ) | Queue that owns the block |
| wr_data | output | LANES*UNIT_W | Block payload, lane k in bits k*UNIT_W upward |

## Verification
The assertions assume that the upstream source holds `in_valid` and its data steady while `in_ready` is low. They also assume that `in_qid` is below NQ. The bench keeps `in_qid` in range by drawing queue numbers only from 0 to NQ-1. It presents each unit until a cycle in which `in_ready` is high, then retires it. The small configuration uses a write period longer than the fill time of one block. This forces the pending FIFO to fill and exercises backpressure under interleaved, single-queue and random-gap traffic.

// File: rtl/tab_pkg.sv
// Shared constants for the tail aggregation buffer.
// Assumes: nothing; only default geometry lives here.
package tab_pkg;
    localparam int unsigned TAB_LANES_DEF  = 8;
    localparam int unsigned TAB_UNIT_W_DEF = 320;
    localparam int unsigned TAB_NQ_DEF     = 8;
endpackage

// File: rtl/tab_stage.sv
// Per-queue staging: holds one partial block per queue with a lane fill pointer.
// When the last lane of a queue arrives, it presents the complete block for one
// cycle (the incoming unit lands directly in the top lane).
// Assumes: accept is only asserted when the downstream FIFO has room.
module tab_stage #(
    parameter int unsigned NQ     = tab_pkg::TAB_NQ_DEF,
    parameter int unsigned LANES  = tab_pkg::TAB_LANES_DEF,
    parameter int unsigned UNIT_W = tab_pkg::TAB_UNIT_W_DEF,
    localparam int unsigned QW    = $clog2(NQ),
    localparam int unsigned PW    = $clog2(LANES),
    localparam int unsigned BLK_W = LANES * UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [QW-1:0]     qid,
    input  logic [UNIT_W-1:0] unit,
    output logic              blk_done,
    output logic [BLK_W-1:0]  blk_data
);
    logic [PW-1:0]     fill [NQ];
    logic [UNIT_W-1:0] lane_mem [NQ][LANES];
    logic              last;

    // Last lane of the addressed queue is being filled.
    always_comb last = (fill[qid] == PW'(LANES - 1));

    // Fill pointers advance per accepted unit and wrap after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) fill[q] <= '0;
        end else if (accept) begin
            fill[qid] <= last ? '0 : fill[qid] + PW'(1);
        end
    end

    // Store the unit into its lane; the last lane bypasses storage.
    always_ff @(posedge clk) begin
        if (accept && !last) lane_mem[qid][fill[qid]] <= unit;
    end

    always_comb blk_done = accept && last;

    // Assemble the block: stored lanes below, incoming unit on top.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == LANES - 1) begin : g_top
            assign blk_data[k*UNIT_W +: UNIT_W] = unit;
        end else begin : g_low
            assign blk_data[k*UNIT_W +: UNIT_W] = lane_mem[qid][k];
        end
    end

    // R2: a non-final unit advances its queue's pointer by one.
    a_r2_fill_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last) |=> fill[$past(qid)] == $past(fill[qid]) + PW'(1));
    // R4: the final unit returns its queue's pointer to lane 0.
    a_r4_fill_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> fill[$past(qid)] == '0);
endmodule

// File: rtl/tab_pend_fifo.sv
// Pending-write FIFO holding complete blocks (queue id plus payload) in order.
// Assumes: DEPTH is a power of two, at least 2; caller never pushes when full.
module tab_pend_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_ent,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ent;
    end

    always_comb begin
        head  = mem[rd_ptr];
        full  = (count == (AW+1)'(DEPTH));
        empty = (count == '0);
    end

    // R6: nothing is written into a full FIFO, nothing read from an empty one.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tab_wr_pacer.sv
// Write pacer: releases at most one block per WR_PERIOD cycles.
// Assumes: WR_PERIOD >= 2.
module tab_wr_pacer #(
    parameter int unsigned WR_PERIOD = 8,
    localparam int unsigned CW       = $clog2(WR_PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic avail,
    output logic pop
);
    logic [CW-1:0] cool;

    always_comb pop = avail && (cool == '0);

    // Cooldown restarts on each release and counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cool <= '0;
        else if (pop)          cool <= CW'(WR_PERIOD - 1);
        else if (cool != '0)   cool <= cool - CW'(1);
    end
endmodule

// File: rtl/tail_agg_buffer.sv
// Per-queue tail aggregation buffer top: stages units per queue, queues full
// blocks, and issues paced wide write requests from a registered output.
// Assumes: in_qid < NQ; source holds unit while in_ready is low.
module tail_agg_buffer #(
    parameter int unsigned NQ         = tab_pkg::TAB_NQ_DEF,
    parameter int unsigned LANES      = tab_pkg::TAB_LANES_DEF,
    parameter int unsigned UNIT_W     = tab_pkg::TAB_UNIT_W_DEF,
    parameter int unsigned PEND_DEPTH = 4,
    parameter int unsigned WR_PERIOD  = 8,
    localparam int unsigned QW        = $clog2(NQ),
    localparam int unsigned BLK_W     = LANES * UNIT_W,
    localparam int unsigned ENT_W     = QW + BLK_W,
    localparam int unsigned SW        = $clog2(WR_PERIOD + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [QW-1:0]     in_qid,
    input  logic [UNIT_W-1:0] in_data,
    output logic              wr_valid,
    output logic [QW-1:0]     wr_qid,
    output logic [BLK_W-1:0]  wr_data
);
    logic             accept, blk_done, pend_full, pend_empty, pop;
    logic [BLK_W-1:0] blk_data;
    logic [ENT_W-1:0] head;

    always_comb begin
        in_ready = !pend_full;
        accept   = in_valid && in_ready;
    end

    tab_stage #(.NQ(NQ), .LANES(LANES), .UNIT_W(UNIT_W)) i_stage (
        .clk(clk), .rst_n(rst_n), .accept(accept), .qid(in_qid),
        .unit(in_data), .blk_done(blk_done), .blk_data(blk_data)
    );

    tab_pend_fifo #(.DEPTH(PEND_DEPTH), .W(ENT_W)) i_pend (
        .clk(clk), .rst_n(rst_n), .push(blk_done),
        .push_ent({in_qid, blk_data}), .pop(pop), .head(head),
        .full(pend_full), .empty(pend_empty)
    );

    tab_wr_pacer #(.WR_PERIOD(WR_PERIOD)) i_pacer (
        .clk(clk), .rst_n(rst_n), .avail(!pend_empty), .pop(pop)
    );

    // Registered write request: one-cycle pulse per released block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_qid   <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= pop;
            if (pop) {wr_qid, wr_data} <= head;
        end
    end

    // Checker counter: cycles since the last write request (saturating).
    logic [SW-1:0] since_wr;
    logic          seen_wr;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_wr <= '0;
            seen_wr  <= 1'b0;
        end else if (wr_valid) begin
            since_wr <= SW'(1);
            seen_wr  <= 1'b1;
        end else if (since_wr < SW'(WR_PERIOD)) begin
            since_wr <= since_wr + SW'(1);
        end
    end

    // R5: write requests keep the memory's access period.
    a_r5_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && seen_wr) |-> since_wr >= SW'(WR_PERIOD));
    // R7: each request is a single-cycle pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R8: a held unit is not taken while the FIFO stays full.
    a_r8_stall_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !pop) |=> !in_ready);

    initial begin
        assert (WR_PERIOD >= LANES) else $error("R5: WR_PERIOD below LANES");
    end
endmodule

// File: tb/test_tail_agg_buffer.sv
// Self-checking bench: small geometry, several traffic patterns, reference
// model of per-queue lane order and global completion order.
module test_tail_agg_buffer;
    localparam int NQ = 4, LANES = 8, UW = 8, DEPTH = 2, PER = 12;
    localparam int QW = $clog2(NQ), BW = LANES * UW;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          in_valid = 1'b0, in_ready;
    logic [QW-1:0] in_qid = '0;
    logic [UW-1:0] in_data = '0;
    logic          wr_valid;
    logic [QW-1:0] wr_qid;
    logic [BW-1:0] wr_data;

    always #2 clk = ~clk;

    tail_agg_buffer #(.NQ(NQ), .LANES(LANES), .UNIT_W(UW),
                      .PEND_DEPTH(DEPTH), .WR_PERIOD(PER)) i_tail_agg_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_qid(in_qid), .in_data(in_data), .wr_valid(wr_valid),
        .wr_qid(wr_qid), .wr_data(wr_data)
    );

    int nvec = 0, nbad = 0, cyc = 0, last_wr = -1, stalls = 0;
    bit done = 0;
    logic [UW-1:0] part [NQ][LANES];
    int            pcnt [NQ];
    logic [BW-1:0] exp_d [$];
    logic [QW-1:0] exp_q [$];
    logic [UW-1:0] seq = '0;
    logic [15:0]   lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Output monitor (R2, R3, R4, R5, R7).
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_d.size() == 0) begin
                chk(0, "R4 unexpected block", wr_data, '0);
            end else begin
                chk(wr_data == exp_d[0], "R2 lane order", wr_data, exp_d[0]);
                chk(wr_qid == exp_q[0], "R3 queue id", BW'(wr_qid), BW'(exp_q[0]));
                void'(exp_d.pop_front());
                void'(exp_q.pop_front());
            end
            if (last_wr >= 0)
                chk(cyc - last_wr >= PER, "R5 spacing", BW'(cyc - last_wr), BW'(PER));
            last_wr = cyc;
        end
    end

    // Present one unit until taken; R6 R8: model records only taken units.
    task automatic send(input int q);
        logic [BW-1:0] blk;
        @(negedge clk);
        in_valid = 1'b1;
        in_qid   = QW'(q);
        in_data  = seq;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        part[q][pcnt[q]] = seq;
        pcnt[q]++;
        if (pcnt[q] == LANES) begin
            for (int k = 0; k < LANES; k++) blk[k*UW +: UW] = part[q][k];
            exp_d.push_back(blk);
            exp_q.push_back(QW'(q));
            pcnt[q] = 0;
        end
        seq = seq + 1'b1;
        #1 in_valid = 1'b0;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) pcnt[q] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(!wr_valid, "R1 wr_valid", BW'(wr_valid), '0);
        chk(in_ready, "R1 in_ready", BW'(in_ready), BW'(1));

        // Pattern 1: round-robin interleave across all queues.
        for (int i = 0; i < 16 * NQ; i++) send(i % NQ);
        // Pattern 2: single-queue back-to-back burst, forces backpressure.
        for (int i = 0; i < 48; i++) send(2);
        // Pattern 3: pseudo-random queues with random idle gaps.
        for (int i = 0; i < 300; i++) begin
            step_lfsr();
            send(int'(lfsr[1:0]) % NQ);
            if (lfsr[7:6] == 2'b11) repeat (int'(lfsr[10:8])) @(negedge clk);
        end
        // Pattern 4: descending queue sweep, burst lengths 1..LANES.
        for (int len = 1; len <= LANES; len++)
            for (int q = NQ - 1; q >= 0; q--)
                for (int j = 0; j < len; j++) send(q);
        // Flush: complete every partial block (R4 order, R6 nothing lost).
        for (int q = 0; q < NQ; q++)
            while (pcnt[q] != 0) send(q);
        repeat ((DEPTH + 4) * PER + 20) @(negedge clk);
        chk(exp_d.size() == 0, "R6 all blocks emitted", BW'(exp_d.size()), '0);
        chk(stalls > 0, "R6 backpressure seen", BW'(stalls), BW'(1));
        chk(!wr_valid && in_ready, "R1 idle after drain", BW'(wr_valid), '0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule